// File: doc/BRIEF.md
# Port Partition and Jabber Monitor

This block sits beside one port of a dual-speed repeater and decides whether that port may take part in the network. It watches the port's receive carrier, its transmit activity, the collision indication and a one-cycle bit-time tick from the port's clocking logic. Because every duration is measured in ticks, the same machine serves a 10 Mb/s port and a 100 Mb/s port.

A port that collides too often, or that sits in one collision for too long, is isolated (partitioned). Its receive input is then ignored, but the repeater keeps sending traffic to it. One long, clean packet in either direction brings it back. A reception that runs far too long (jabber) blocks both the receive and the transmit path until carrier goes away. At 100 Mb/s, jabber also partitions the port. Each speed has its own disable bit for partitioning and for jabber protection.

An activity episode starts when receive carrier or transmit activity rises and ends when both are low. The episode collided if the collision input was high in any cycle of it.

Top module: `port_isolation_guard`

## Requirements
- R1: After reset, `partitioned` and `jab_inhibit` are 0, and `rx_accept` follows `rx_carrier`.
- R2: With `spd_is_10m`=1 and `lim10_raise`=0, the port becomes partitioned in the cycle after the 32nd consecutive collided episode ends. After the 31st it stays connected.
- R3: The consecutive-collision limit is 64 when `spd_is_10m`=0, and also at 10M when `lim10_raise`=1. The 63rd collided episode does not partition the port; the 64th does.
- R4: An episode that ends without a collision resets the consecutive-collision count to zero.
- R5: A collision that stays high for more than 1024 ticks partitions the port at either speed. The flag rises two clock edges after the 1025th tick.
- R6: A partitioned port reconnects at the end of an episode that lasted more than 512 ticks, had no collision and did not hit jabber. An episode of exactly 512 ticks does not reconnect it.
- R7: Once receive carrier has lasted more than 65536 ticks, `jab_inhibit` rises. It falls on the first edge with `rx_carrier` low.
- R8: Entering jabber also partitions the port when `spd_is_10m`=0. At 10M it leaves `partitioned` unchanged.
- R9: While the partition-disable bit for the current speed (`part_off_10` or `part_off_100`) is 1, `partitioned` is 0 from the next edge on.
- R10: While the jabber-disable bit for the current speed (`jab_off_10` or `jab_off_100`) is 1, `jab_inhibit` is 0 from the next edge on.
- R11: `rx_accept` is 1 only while `rx_carrier` is 1 and the port is neither partitioned nor jabbering. Partitioning alone never raises `jab_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| spd_is_10m | input | 1 | Port speed: 1 = 10M, 0 = 100M |
| lim10_raise | input | 1 | Raises the 10M collision limit from 32 to 64 |
| part_off_10 | input | 1 | Disables partitioning at 10M |
| part_off_100 | input | 1 | Disables partitioning at 100M |
| jab_off_10 | input | 1 | Disables jabber protection at 10M |
| jab_off_100 | input | 1 | Disables jabber protection at 100M |
| rx_carrier | input | 1 | Port receive carrier |
| tx_active | input | 1 | Repeater is transmitting to the port |
| coll | input | 1 | Collision seen on the port |
| partitioned | output | 1 | Port is isolated from the repeater input |
| jab_inhibit | output | 1 | Receive and transmit paths are blocked |
| rx_accept | output | 1 | Port's receive data may be repeated |

## Verification
Some properties are checked on every cycle: the disable bits forcing their flags low on the next edge, jabber release on carrier loss, jabber rising only under carrier, and partition falling only after a disable or a clean long episode. Other behaviour depends on a history of many episodes or tens of thousands of ticks. This covers the exact collision-limit edges at 31/32 and 63/64, the clearing effect of a clean episode, the 1024- and 512-tick boundaries, and the speed-dependent link between jabber and partition. Only the bench's directed scenarios show those, by counting cycles to the exact edge on which each flag moves.

// File: rtl/port_guard_pkg.sv
package port_guard_pkg;

  typedef enum logic {
    RATE_100 = 1'b0,
    RATE_10  = 1'b1
  } link_rate_e;

  function automatic int unsigned cc_limit(link_rate_e rate, logic raise,
                                           int unsigned lo, int unsigned hi);
    return (rate == RATE_10 && !raise) ? lo : hi;
  endfunction

endpackage

// File: rtl/sat_tick_counter.sv
module sat_tick_counter #(
  parameter int unsigned LIMIT = 512,
  localparam int unsigned W = $clog2(LIMIT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic over
);

  localparam logic [W-1:0] TOP = W'(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (tick && cnt_q != TOP) begin
      cnt_d  = cnt_q + W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign over = (cnt_q > W'(LIMIT));

endmodule

// File: rtl/collision_streak.sv
module collision_streak #(
  parameter int unsigned CAP = 64,
  localparam int unsigned W = $clog2(CAP + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         end_ep,
  input  logic         hit,
  input  logic [W-1:0] limit,
  output logic         reach
);

  logic [W-1:0] cnt_q, cnt_d, inc;
  logic         cnt_en;

  assign inc = (cnt_q == W'(CAP)) ? cnt_q : cnt_q + W'(1);

  always_comb begin
    cnt_en = clr | end_ep;
    if (clr)      cnt_d = '0;
    else if (hit) cnt_d = inc;
    else          cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign reach = end_ep & hit & (inc >= limit);

endmodule

// File: rtl/port_isolation_guard.sv
module port_isolation_guard
  import port_guard_pkg::*;
#(
  parameter int unsigned CC_LIM_LO      = 32,
  parameter int unsigned CC_LIM_HI      = 64,
  parameter int unsigned LONG_COLL_BITS = 1024,
  parameter int unsigned RECON_BITS     = 512,
  parameter int unsigned JAB_BITS       = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic spd_is_10m,
  input  logic lim10_raise,
  input  logic part_off_10,
  input  logic part_off_100,
  input  logic jab_off_10,
  input  logic jab_off_100,
  input  logic rx_carrier,
  input  logic tx_active,
  input  logic coll,
  output logic partitioned,
  output logic jab_inhibit,
  output logic rx_accept
);

  localparam int unsigned CW = $clog2(CC_LIM_HI + 1);

  link_rate_e rate;
  logic [CW-1:0] limit;
  logic act, act_q, end_ep;
  logic coll_seen_q, coll_seen_d, coll_any;
  logic part_dis, jab_dis;
  logic part_q, part_d, jab_q, jab_d;
  logic ep_over, long_over, jab_over;
  logic streak_reach, reconnect, jab_set;

  assign rate     = spd_is_10m ? RATE_10 : RATE_100;
  assign limit    = CW'(cc_limit(rate, lim10_raise, CC_LIM_LO, CC_LIM_HI));
  assign part_dis = spd_is_10m ? part_off_10 : part_off_100;
  assign jab_dis  = spd_is_10m ? jab_off_10  : jab_off_100;

  assign act      = rx_carrier | tx_active;
  assign end_ep   = act_q & ~act;
  assign coll_any = coll_seen_q | coll;

  // Episode length, collision duration and receive length counters
  sat_tick_counter #(.LIMIT(RECON_BITS)) i_ep_len (
    .clk(clk), .rst_n(rst_n), .run(act), .tick(bit_tick), .over(ep_over));

  sat_tick_counter #(.LIMIT(LONG_COLL_BITS)) i_coll_len (
    .clk(clk), .rst_n(rst_n), .run(coll), .tick(bit_tick), .over(long_over));

  sat_tick_counter #(.LIMIT(JAB_BITS)) i_rx_len (
    .clk(clk), .rst_n(rst_n), .run(rx_carrier), .tick(bit_tick), .over(jab_over));

  collision_streak #(.CAP(CC_LIM_HI)) i_streak (
    .clk(clk), .rst_n(rst_n), .clr(part_dis | reconnect), .end_ep(end_ep),
    .hit(coll_any), .limit(limit), .reach(streak_reach));

  assign jab_set   = rx_carrier & jab_over & ~jab_dis & ~jab_q;
  assign reconnect = part_q & end_ep & ~coll_any & ep_over & ~jab_q;

  always_comb begin
    coll_seen_d = coll_seen_q;
    if (end_ep)          coll_seen_d = 1'b0;
    else if (act & coll) coll_seen_d = 1'b1;

    jab_d = ~jab_dis & rx_carrier & (jab_q | jab_over);

    if (part_dis)    part_d = 1'b0;
    else if (part_q) part_d = ~reconnect;
    else             part_d = streak_reach | long_over | (jab_set & (rate == RATE_100));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      coll_seen_q <= 1'b0;
      jab_q       <= 1'b0;
      part_q      <= 1'b0;
    end else begin
      act_q       <= act;
      coll_seen_q <= coll_seen_d;
      jab_q       <= jab_d;
      part_q      <= part_d;
    end
  end

  assign partitioned = part_q;
  assign jab_inhibit = jab_q;
  assign rx_accept   = rx_carrier & ~part_q & ~jab_q;

  // Partition disable clears the flag on the next edge
  assert_part_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    part_dis |=> !partitioned);

  // Jabber disable clears the inhibit on the next edge
  assert_jab_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    jab_dis |=> !jab_inhibit);

  // Loss of carrier releases jabber
  assert_jab_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_carrier |=> !jab_inhibit);

  // Jabber only starts under carrier
  assert_jab_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_inhibit) |-> $past(rx_carrier));

  // Partition leaves only through disable or a clean long episode
  assert_reconnect_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(partitioned) |-> ($past(part_dis) || $past(end_ep && !coll_any && ep_over)));

endmodule

// File: tb/test_port_isolation_guard.sv
module test_port_isolation_guard;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_tick, spd_is_10m, lim10_raise;
  logic part_off_10, part_off_100, jab_off_10, jab_off_100;
  logic rx_carrier, tx_active, coll;
  logic partitioned, jab_inhibit, rx_accept;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  port_isolation_guard i_port_isolation_guard (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .spd_is_10m(spd_is_10m),
    .lim10_raise(lim10_raise), .part_off_10(part_off_10), .part_off_100(part_off_100),
    .jab_off_10(jab_off_10), .jab_off_100(jab_off_100), .rx_carrier(rx_carrier),
    .tx_active(tx_active), .coll(coll), .partitioned(partitioned),
    .jab_inhibit(jab_inhibit), .rx_accept(rx_accept));

  task automatic check(input string req, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic spd);
    rst_n = 1'b0; bit_tick = 1'b1; spd_is_10m = spd; lim10_raise = 1'b0;
    part_off_10 = 1'b0; part_off_100 = 1'b0; jab_off_10 = 1'b0; jab_off_100 = 1'b0;
    rx_carrier = 1'b0; tx_active = 1'b0; coll = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
  endtask

  // One activity episode of len ticks, optionally collided in its first cycle
  task automatic episode(input int len, input logic with_coll);
    rx_carrier = 1'b1; coll = with_coll;
    cycles(1);
    coll = 1'b0;
    cycles(len - 1);
    rx_carrier = 1'b0;
    cycles(2);
  endtask

  task automatic t_reset_r1;
    do_reset(1'b1);
    check("R1 partitioned", partitioned, 1'b0);
    check("R1 jab_inhibit", jab_inhibit, 1'b0);
    rx_carrier = 1'b1; #1;
    check("R1 rx_accept", rx_accept, 1'b1);
    rx_carrier = 1'b0; cycles(2);
  endtask

  task automatic t_limit10_r2;
    do_reset(1'b1);
    for (int i = 0; i < 31; i++) episode(2, 1'b1);
    check("R2 31 collisions", partitioned, 1'b0);
    episode(2, 1'b1);
    check("R2 32 collisions", partitioned, 1'b1);
  endtask

  task automatic t_limit64_r3;
    do_reset(1'b0);
    for (int i = 0; i < 63; i++) episode(2, 1'b1);
    check("R3 100M 63", partitioned, 1'b0);
    episode(2, 1'b1);
    check("R3 100M 64", partitioned, 1'b1);
    do_reset(1'b1);
    lim10_raise = 1'b1;
    for (int i = 0; i < 63; i++) episode(2, 1'b1);
    check("R3 10M raised 63", partitioned, 1'b0);
    episode(2, 1'b1);
    check("R3 10M raised 64", partitioned, 1'b1);
  endtask

  task automatic t_clear_r4;
    do_reset(1'b1);
    for (int i = 0; i < 31; i++) episode(2, 1'b1);
    episode(3, 1'b0);
    for (int i = 0; i < 31; i++) episode(2, 1'b1);
    check("R4 streak cleared", partitioned, 1'b0);
    episode(2, 1'b1);
    check("R4 new streak reaches 32", partitioned, 1'b1);
  endtask

  task automatic t_long_coll_r5;
    do_reset(1'b0);
    rx_carrier = 1'b1; coll = 1'b1;
    cycles(1025);
    check("R5 not yet", partitioned, 1'b0);
    cycles(1);
    check("R5 long collision", partitioned, 1'b1);
    check("R11 accept blocked", rx_accept, 1'b0);
    coll = 1'b0; rx_carrier = 1'b0; cycles(2);
  endtask

  task automatic t_reconnect_r6;
    do_reset(1'b1);
    for (int i = 0; i < 32; i++) episode(2, 1'b1);
    check("R6 partitioned", partitioned, 1'b1);
    check("R11 no jabber from partition", jab_inhibit, 1'b0);
    rx_carrier = 1'b1; #1;
    check("R11 input ignored", rx_accept, 1'b0);
    rx_carrier = 1'b0; cycles(2);
    episode(512, 1'b0);
    check("R6 512 keeps", partitioned, 1'b1);
    episode(513, 1'b0);
    check("R6 513 reconnects", partitioned, 1'b0);
    rx_carrier = 1'b1; #1;
    check("R11 accept again", rx_accept, 1'b1);
    rx_carrier = 1'b0; cycles(2);
  endtask

  task automatic t_jab100_r7_r8;
    do_reset(1'b0);
    rx_carrier = 1'b1;
    cycles(65537);
    check("R7 not yet", jab_inhibit, 1'b0);
    check("R8 not yet", partitioned, 1'b0);
    cycles(1);
    check("R7 jabber", jab_inhibit, 1'b1);
    check("R8 100M partitions", partitioned, 1'b1);
    check("R11 accept blocked", rx_accept, 1'b0);
    rx_carrier = 1'b0;
    cycles(1);
    check("R7 release", jab_inhibit, 1'b0);
    cycles(2);
    check("R6 jabbered episode keeps partition", partitioned, 1'b1);
    part_off_100 = 1'b1;
    cycles(1);
    check("R9 disable clears", partitioned, 1'b0);
  endtask

  task automatic t_jab10_r8_r10;
    do_reset(1'b1);
    rx_carrier = 1'b1;
    cycles(65538);
    check("R7 10M jabber", jab_inhibit, 1'b1);
    check("R8 10M no partition", partitioned, 1'b0);
    jab_off_10 = 1'b1;
    cycles(1);
    check("R10 disable clears", jab_inhibit, 1'b0);
    cycles(3);
    check("R10 stays clear", jab_inhibit, 1'b0);
    rx_carrier = 1'b0; cycles(2);
  endtask

  task automatic t_part_disable_r9;
    do_reset(1'b1);
    part_off_10 = 1'b1;
    for (int i = 0; i < 32; i++) episode(2, 1'b1);
    check("R9 10M disabled", partitioned, 1'b0);
  endtask

  initial begin
    t_reset_r1;
    t_limit10_r2;
    t_limit64_r3;
    t_clear_r4;
    t_long_coll_r5;
    t_reconnect_r6;
    t_part_disable_r9;
    t_jab100_r7_r8;
    t_jab10_r8_r10;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule